// File: doc/BRIEF.md
# Cross-CPU Start and Halt Controller

This block lets a boot processor bring the other processors of a multi-core cluster into operation. It has two writable registers at neighbouring addresses: a parameter register that holds a start address, and a command register whose write triggers an action on one selected processor. Each processor gets three outputs from the block: a start program counter value, a one-cycle strobe telling the core to load that value, and a halt level that keeps the core stopped.

After reset only processor 0 runs and every other processor is held in halt. To start a secondary processor, software first writes the start address into the parameter register. It then issues a set-PC command to that processor, and finally issues a separate release command that drops the processor's halt. The controller is parameterised by the number of processors and by the width of the program counter.

Top module: `cpu_launch_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `halt` is 1 for every processor except processor 0, whose halt is 0. Every `start_pc` slot reads 0 and `pc_load` is all zeros.
- R2: A write with `reg_addr` = 1 stores the low PC_W bits of `reg_wdata` in the parameter register. That write by itself changes no output.
- R3: A write with `reg_addr` = 0 is a command. Bits 7:0 hold the opcode and bits 15:8 hold the target processor index. Bits above 15 are ignored.
- R4: Opcode 0x04 copies the parameter register into the target's `start_pc` slot. It also raises that target's `pc_load` bit for exactly the one cycle after the write. No other processor's outputs change.
- R5: Opcode 0x02 clears the target's `halt` bit from the cycle after the write onward.
- R6: A set-PC command leaves every `halt` bit unchanged. A release command leaves every `start_pc` slot unchanged and raises no `pc_load` bit.
- R7: A command whose target index is NUM_CPU or larger has no effect on any output. This includes indices whose low bits match an existing processor.
- R8: A command with any opcode other than 0x04 or 0x02 has no effect on any output.
- R9: A release command to a processor that is already running leaves all outputs unchanged.
- R10: Once a `halt` bit is 0, it stays 0 until the next reset.
- R11: Changing the parameter register after a set-PC command does not alter a `start_pc` slot that has already been loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 1 | 0 selects the command register, 1 selects the parameter register |
| reg_wdata | input | DATA_W | Write data |
| start_pc | output | NUM_CPU*PC_W | Start program counter per processor; processor i occupies bits i*PC_W upward |
| pc_load | output | NUM_CPU | One-cycle load strobe per processor |
| halt | output | NUM_CPU | Halt level per processor |

## Verification
The hardest case to reach from the ports is an out-of-range target index whose low bits alias a real processor. For example, index 5 or 4 on a four-processor build would hit processors 1 and 0 if the index were truncated. The stimulus targets these indices, and index 255, right after writing a fresh parameter value. Any stray load or release would then show up as a new value or a dropped halt on the aliased processor. A second hard case is repeated release of a running processor mixed with back-to-back set-PC commands to two different processors. The reference model is compared on every clock, so a strobe that lasts two cycles or lands on the wrong processor is caught.

// File: rtl/launch_pkg.sv
package launch_pkg;

  // Command opcodes; their values are part of the software contract.
  typedef enum logic [7:0] {
    OP_SET_PC  = 8'h04,
    OP_RELEASE = 8'h02
  } launch_op_e;

  // Field positions inside a command word.
  localparam int CMD_OP_LSB  = 0;
  localparam int CMD_IDX_LSB = 8;
  localparam int CMD_FLD_W   = 8;

  // Register offsets, adjacent by contract.
  localparam logic ADDR_CMD   = 1'b0;
  localparam logic ADDR_PARAM = 1'b1;

  function automatic logic [CMD_FLD_W-1:0] cmd_opcode(input logic [15:0] word);
    return word[CMD_OP_LSB +: CMD_FLD_W];
  endfunction

  function automatic logic [CMD_FLD_W-1:0] cmd_target(input logic [15:0] word);
    return word[CMD_IDX_LSB +: CMD_FLD_W];
  endfunction

  function automatic logic target_in_range(input logic [CMD_FLD_W-1:0] idx,
                                           input int unsigned n_cpu);
    return {24'd0, idx} < n_cpu;
  endfunction

  function automatic logic opcode_known(input logic [CMD_FLD_W-1:0] op);
    return (op == OP_SET_PC) || (op == OP_RELEASE);
  endfunction

endpackage

// File: rtl/launch_param_reg.sv
module launch_param_reg #(
  parameter int PC_W   = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [PC_W-1:0]   param_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)      param_q <= '0;
    else if (wr_en)  param_q <= wdata[PC_W-1:0];
  end

endmodule

// File: rtl/launch_cmd_decode.sv
module launch_cmd_decode
  import launch_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int DATA_W  = 32
) (
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NUM_CPU-1:0] load_sel,
  output logic [NUM_CPU-1:0] release_sel,
  output logic              cmd_valid
);

  logic [CMD_FLD_W-1:0] op;
  logic [CMD_FLD_W-1:0] tgt;

  assign op        = cmd_opcode(wdata[15:0]);
  assign tgt       = cmd_target(wdata[15:0]);
  assign cmd_valid = cmd_wr && target_in_range(tgt, NUM_CPU) && opcode_known(op);

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_sel
    logic hit;
    assign hit            = cmd_valid && (tgt == CMD_FLD_W'(i));
    assign load_sel[i]    = hit && (op == OP_SET_PC);
    assign release_sel[i] = hit && (op == OP_RELEASE);
  end

endmodule

// File: rtl/launch_cpu_slot.sv
module launch_cpu_slot #(
  parameter int PC_W          = 32,
  parameter bit HALT_AT_RESET = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_hit,
  input  logic            release_hit,
  input  logic [PC_W-1:0] param_q,
  output logic [PC_W-1:0] pc_q,
  output logic            load_q,
  output logic            halt_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      load_q <= 1'b0;
      halt_q <= HALT_AT_RESET;
    end else begin
      load_q <= load_hit;
      if (load_hit)    pc_q   <= param_q;
      if (release_hit) halt_q <= 1'b0;
    end
  end

endmodule

// File: rtl/cpu_launch_ctrl.sv
module cpu_launch_ctrl
  import launch_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int PC_W    = 32,
  parameter int DATA_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic                    reg_addr,
  input  logic [DATA_W-1:0]       reg_wdata,
  output logic [NUM_CPU*PC_W-1:0] start_pc,
  output logic [NUM_CPU-1:0]      pc_load,
  output logic [NUM_CPU-1:0]      halt
);

  localparam int PCV_W = NUM_CPU * PC_W;

  logic               cmd_wr;
  logic               param_wr;
  logic [PC_W-1:0]    param_q;
  logic [NUM_CPU-1:0] load_sel;
  logic [NUM_CPU-1:0] release_sel;
  logic               cmd_valid;
  logic [PCV_W-1:0]   pc_vec;

  assign cmd_wr   = reg_wr && (reg_addr == ADDR_CMD);
  assign param_wr = reg_wr && (reg_addr == ADDR_PARAM);

  launch_param_reg #(.PC_W(PC_W), .DATA_W(DATA_W)) u_param (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (param_wr),
    .wdata   (reg_wdata),
    .param_q (param_q)
  );

  launch_cmd_decode #(.NUM_CPU(NUM_CPU), .DATA_W(DATA_W)) u_dec (
    .cmd_wr      (cmd_wr),
    .wdata       (reg_wdata),
    .load_sel    (load_sel),
    .release_sel (release_sel),
    .cmd_valid   (cmd_valid)
  );

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
    launch_cpu_slot #(.PC_W(PC_W), .HALT_AT_RESET(i != 0)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_hit    (load_sel[i]),
      .release_hit (release_sel[i]),
      .param_q     (param_q),
      .pc_q        (pc_vec[i*PC_W +: PC_W]),
      .load_q      (pc_load[i]),
      .halt_q      (halt[i])
    );
  end

  assign start_pc = pc_vec;

endmodule

// File: rtl/launch_ctrl_chk.sv
module launch_ctrl_chk #(
  parameter int NUM_CPU = 4,
  parameter int PC_W    = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_CPU*PC_W-1:0] start_pc,
  input logic [NUM_CPU-1:0]      pc_load,
  input logic [NUM_CPU-1:0]      halt,
  input logic [PC_W-1:0]         param_q,
  input logic [NUM_CPU-1:0]      load_sel,
  input logic [NUM_CPU-1:0]      release_sel
);

  // R1
  boot_cpu_runs_chk: assert property (@(posedge clk) disable iff (!rst_n) !halt[0]);

  // R4
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(pc_load));

  // R4
  strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pc_load) |-> $past(|load_sel));

  // R10
  halt_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt & ~$past(halt)) == '0);

  // R6
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|pc_load) |-> $stable(start_pc));

  // R6
  load_keeps_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|load_sel) |=> $stable(halt));

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_chk
    // R4
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_load[i] && !load_sel[i]) |=> !pc_load[i]);
    // R4
    pc_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_sel[i] |=> (start_pc[i*PC_W +: PC_W] == $past(param_q)));
    // R5
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      release_sel[i] |=> !halt[i]);
  end

endmodule

bind cpu_launch_ctrl launch_ctrl_chk #(.NUM_CPU(NUM_CPU), .PC_W(PC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_pc    (start_pc),
  .pc_load     (pc_load),
  .halt        (halt),
  .param_q     (param_q),
  .load_sel    (load_sel),
  .release_sel (release_sel)
);

// File: tb/cpu_launch_ctrl_test.sv
module cpu_launch_ctrl_test;

  localparam int  N      = 4;
  localparam int  PW     = 32;
  localparam int  DW     = 32;
  localparam time CLK_PD = 10ns;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reg_wr = 1'b0;
  logic            reg_addr = 1'b0;
  logic [DW-1:0]   reg_wdata = '0;
  logic [N*PW-1:0] start_pc;
  logic [N-1:0]    pc_load;
  logic [N-1:0]    halt;

  cpu_launch_ctrl #(.NUM_CPU(N), .PC_W(PW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .start_pc(start_pc), .pc_load(pc_load), .halt(halt)
  );

  always #(CLK_PD/2) clk = ~clk;

  // Behavioural reference model.
  logic [PW-1:0] m_pc   [N];
  logic          m_load [N];
  logic          m_halt [N];
  logic [PW-1:0] m_param;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    checking = 0;
  string cur_req  = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_pc[i] = '0; m_load[i] = 1'b0; m_halt[i] = (i != 0);
      end
      m_param = '0;
    end else begin
      for (int i = 0; i < N; i++) m_load[i] = 1'b0;
      if (reg_wr) begin
        if (reg_addr) m_param = reg_wdata[PW-1:0];
        else begin
          int idx;
          int op;
          idx = int'(reg_wdata[15:8]);
          op  = int'(reg_wdata[7:0]);
          if (idx < N) begin
            if (op == 4) begin m_pc[idx] = m_param; m_load[idx] = 1'b1; end
            else if (op == 2) m_halt[idx] = 1'b0;
          end
        end
      end
    end
  end

  // Compare every clock, away from the active edge.
  always @(negedge clk) begin
    if (checking) begin
      bit bad;
      bad = 0;
      n_checks++;
      for (int i = 0; i < N; i++) begin
        if (start_pc[i*PW +: PW] !== m_pc[i] || pc_load[i] !== m_load[i] ||
            halt[i] !== m_halt[i]) begin
          bad = 1;
          $display("FAIL %s cpu%0d: pc=%h load=%b halt=%b expected pc=%h load=%b halt=%b",
                   cur_req, i, start_pc[i*PW +: PW], pc_load[i], halt[i],
                   m_pc[i], m_load[i], m_halt[i]);
        end
      end
      if (bad) n_fail++;
    end
  end

  task automatic wr(input logic a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Explicit directed check with an expected value from the requirement.
  task automatic expect_bit(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  initial begin : watchdog
    #(CLK_PD * 20000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    checking = 1;
    idle(1);
    cur_req = "R1";
    rst_n = 1'b1;
    idle(2);
    expect_bit("R1", halt[0], 1'b0);
    expect_bit("R1", halt[N-1], 1'b1);

    cur_req = "R2"; wr(1'b1, 32'h1000_0040); idle(2);
    cur_req = "R4"; wr(1'b0, 32'h0000_0104);
    expect_bit("R4", pc_load[1], 1'b1);
    idle(1);
    expect_bit("R4", pc_load[1], 1'b0);
    expect_bit("R6", halt[1], 1'b1);
    cur_req = "R5"; wr(1'b0, 32'h0000_0102);
    expect_bit("R5", halt[1], 1'b0);
    cur_req = "R3"; wr(1'b1, 32'h2000_0080); wr(1'b0, 32'hABCD_0304); wr(1'b0, 32'h5A5A_0302);
    expect_bit("R3", halt[3], 1'b0);
    cur_req = "R11"; wr(1'b1, 32'hDEAD_BEEF); idle(3);
    cur_req = "R7"; wr(1'b0, 32'h0000_0504); wr(1'b0, 32'h0000_0404);
    wr(1'b0, 32'h0000_FF04); wr(1'b0, 32'h0000_0602); wr(1'b0, 32'h0000_0402);
    cur_req = "R8";
    for (int op = 0; op < 256; op += 17) begin
      if (op != 4 && op != 2) wr(1'b0, 32'h0000_0200 | op[31:0]);
    end
    wr(1'b0, 32'h0000_0203); wr(1'b0, 32'h0000_0206);
    expect_bit("R8", halt[2], 1'b1);
    cur_req = "R9"; wr(1'b0, 32'h0000_0102); wr(1'b0, 32'h0000_0002); idle(2);
    cur_req = "R6"; wr(1'b1, 32'h0000_3000); wr(1'b0, 32'h0000_0204); wr(1'b0, 32'h0000_0004);
    cur_req = "R4";
    @(negedge clk); reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 32'h0000_0204;
    @(negedge clk); reg_wdata = 32'h0000_0104;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
    idle(2);
    cur_req = "R10"; wr(1'b0, 32'h0000_0202); idle(4);
    expect_bit("R10", halt[2], 1'b0);
    cur_req = "R1";
    @(negedge clk); rst_n = 1'b0; idle(2);
    expect_bit("R1", halt[1], 1'b1);
    rst_n = 1'b1; idle(3);
    checking = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule